// File: doc/BRIEF.md
# Endpoint Buffer Window Allocator

This block keeps the layout of a shared packet buffer RAM that a USB device or host controller splits among six endpoints. Each endpoint has an enable bit, an allocate bit, a geometry setting (unit size and bank count) and an opaque attribute byte. The attribute byte stands for the direction, transfer type, target endpoint number and polling interval. From these the block keeps a byte base address and a byte length for each endpoint's window in the RAM. Moving packet data, the protocol engine and interrupts are outside the block.

Software is expected to set endpoints up in ascending index order. When an endpoint is allocated, its window goes straight after the nearest lower allocated window. The next-higher endpoint's window is then pushed up behind it. When an endpoint is freed, the next-higher window drops into the freed space. Windows two or more indices away never move. This means a later re-allocation with a larger size can make windows overlap. Every endpoint whose window collides with another one raises a conflict flag. Every endpoint whose window runs past the top of the RAM raises an overflow flag.

A single register-write port applies one write per clock. The write names an endpoint, an operation and a data byte. Any change in layout shows on the outputs in the cycle after the write.

Top module: `epbuf_window_alloc`

## Requirements
- R1: After reset, every enable bit, allocate bit, geometry field, attribute byte, base, length, conflict flag and overflow flag reads zero.
- R2: Writes use wr_op 0 for enable (wr_data[0]), 1 for allocate (wr_data[0]), 2 for geometry and 3 for attributes (wr_data[7:0]). A geometry write sets the size code from wr_data[2:0] and the bank code from wr_data[4:3]. An allocated window's length is (8 << size code) times the bank count, where bank code 0 means 1 bank, 1 means 2 banks, and 2 or 3 mean 3 banks.
- R3: Allocating endpoint n sets its base to the end address (base plus length) of the highest-indexed allocated endpoint below n, or to 0 if there is none.
- R4: When endpoint n is allocated and endpoint n+1 is allocated, the base of n+1 becomes the end of n's new window, and the length of n+1 is kept.
- R5: Freeing endpoint n sets its base and length to zero. If endpoint n+1 is allocated, its base becomes the old base of n.
- R6: An allocate or free of endpoint n leaves the bases of all endpoints below n and of n+2 and above unchanged.
- R7: An enable write changes only that endpoint's enable bit. The allocate bit, geometry and attributes keep their values.
- R8: A geometry write to an allocated endpoint changes its geometry outputs but moves no base and changes no length.
- R9: An endpoint's conflict flag is high exactly when it is allocated and its window [base, base+length) intersects the window of another allocated endpoint.
- R10: An endpoint's overflow flag is high exactly when it is allocated and base+length exceeds RAM_BYTES (4096 by default). A window ending exactly at RAM_BYTES does not overflow.
- R11: Layout changes are visible on the cycle after the write. Writing allocate=1 to an allocated endpoint, allocate=0 to a free endpoint, or any write to endpoint indices 6 or 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ep | input | 3 | Target endpoint index |
| wr_op | input | 2 | Operation: 0 enable, 1 allocate, 2 geometry, 3 attributes |
| wr_data | input | 8 | Write data |
| ep_en | output | 6 | Enable bit per endpoint |
| ep_alloc | output | 6 | Allocate bit per endpoint |
| ep_size | output | 18 | 3-bit size code per endpoint |
| ep_bank | output | 12 | 2-bit bank code per endpoint |
| ep_attr | output | 48 | Attribute byte per endpoint |
| win_base | output | 90 | 15-bit window base per endpoint |
| win_len | output | 72 | 12-bit window length per endpoint |
| conflict | output | 6 | Window overlap flag per endpoint |
| overflow | output | 6 | Window past RAM top flag per endpoint |

## Verification
The bases and lengths are held in registers, so a slip in the slide rule appears in the cycle after the write. It shows as a wrong base on the neighbour endpoint, or as a moved base two or more indices away. The conflict and overflow flags are computed from these registers without further storage. Any corrupted base or length therefore changes them in the same cycle it shows on the window outputs. A write that leaks into the wrong field shows one cycle later on the field outputs of that endpoint.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;
   typedef enum logic [1:0] {
      OP_ENABLE = 2'd0,
      OP_ALLOC  = 2'd1,
      OP_GEOM   = 2'd2,
      OP_ATTR   = 2'd3
   } wr_op_e;
endpackage

// File: rtl/epbuf_ep_slot.sv
module epbuf_ep_slot
   import epbuf_pkg::*;
#(
   parameter int SIZE_W = 3,
   parameter int BANK_W = 2,
   parameter int ATTR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  wr_op_e            op,
   input  logic [ATTR_W-1:0] data,
   output logic              en_o,
   output logic              alloc_o,
   output logic [SIZE_W-1:0] size_o,
   output logic [BANK_W-1:0] bank_o,
   output logic [ATTR_W-1:0] attr_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_o    <= 1'b0;
         alloc_o <= 1'b0;
         size_o  <= '0;
         bank_o  <= '0;
         attr_o  <= '0;
      end else if (hit) begin
         case (op)
            OP_ENABLE: en_o    <= data[0];
            OP_ALLOC:  alloc_o <= data[0];
            OP_GEOM: begin
               size_o <= data[SIZE_W-1:0];
               bank_o <= data[SIZE_W +: BANK_W];
            end
            default:   attr_o  <= data;
         endcase
      end
   end

   // R7
   enable_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && op == OP_ENABLE) |=> ($stable(alloc_o) && $stable(size_o) &&
                                    $stable(bank_o) && $stable(attr_o)));
endmodule

// File: rtl/epbuf_win_track.sv
module epbuf_win_track #(
   parameter int NUM_EP = 6,
   parameter int EP_W   = 3,
   parameter int BASE_W = 15,
   parameter int LEN_W  = 12
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           ev_set,
   input  logic                           ev_clr,
   input  logic [EP_W-1:0]                ev_ep,
   input  logic [LEN_W-1:0]               new_len,
   input  logic [NUM_EP-1:0]              alloc_i,
   output logic [NUM_EP-1:0][BASE_W-1:0]  base_q,
   output logic [NUM_EP-1:0][LEN_W-1:0]   len_q
);
   logic [BASE_W-1:0] low_end;
   logic [BASE_W-1:0] new_end;
   logic [BASE_W-1:0] cur_base;

   always_comb begin
      low_end  = '0;
      cur_base = '0;
      for (int m = 0; m < NUM_EP; m++) begin
         if (m < int'(ev_ep) && alloc_i[m])
            low_end = base_q[m] + BASE_W'(len_q[m]);
         if (m == int'(ev_ep))
            cur_base = base_q[m];
      end
      new_end = low_end + BASE_W'(new_len);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_EP; i++) begin
            base_q[i] <= '0;
            len_q[i]  <= '0;
         end
      end else begin
         for (int i = 0; i < NUM_EP; i++) begin
            if (ev_set && i == int'(ev_ep)) begin
               base_q[i] <= low_end;
               len_q[i]  <= new_len;
            end else if (ev_clr && i == int'(ev_ep)) begin
               base_q[i] <= '0;
               len_q[i]  <= '0;
            end else if (i == int'(ev_ep) + 1 && alloc_i[i]) begin
               if (ev_set)
                  base_q[i] <= new_end;
               else if (ev_clr)
                  base_q[i] <= cur_base;
            end
         end
      end
   end

   // R3
   first_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_set && ev_ep == '0) |=> (base_q[0] == '0));

   for (genvar g = 0; g < NUM_EP; g++) begin : g_chk
      // R6
      far_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((ev_set || ev_clr) && (g < int'(ev_ep) || g > int'(ev_ep) + 1))
         |=> $stable(base_q[g]));
      if (g > 0) begin : g_nb
         // R4
         slide_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_set && int'(ev_ep) == g - 1 && alloc_i[g])
            |=> (base_q[g] == base_q[g-1] + BASE_W'(len_q[g-1])));
         // R5
         slide_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_clr && int'(ev_ep) == g - 1 && alloc_i[g])
            |=> (base_q[g] == $past(base_q[g-1])));
      end
   end
endmodule

// File: rtl/epbuf_overlap.sv
module epbuf_overlap #(
   parameter int NUM_EP    = 6,
   parameter int BASE_W    = 15,
   parameter int LEN_W     = 12,
   parameter int RAM_BYTES = 4096
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_EP-1:0]             alloc_i,
   input  logic [NUM_EP-1:0][BASE_W-1:0] base_i,
   input  logic [NUM_EP-1:0][LEN_W-1:0]  len_i,
   output logic [NUM_EP-1:0]             conflict_o,
   output logic [NUM_EP-1:0]             overflow_o
);
   localparam int END_W = BASE_W + 1;

   logic [NUM_EP-1:0][END_W-1:0] end_a;

   for (genvar i = 0; i < NUM_EP; i++) begin : g_end
      assign end_a[i] = END_W'(base_i[i]) + END_W'(len_i[i]);
      assign overflow_o[i] = alloc_i[i] && (end_a[i] > END_W'(RAM_BYTES));
   end

   always_comb begin
      conflict_o = '0;
      for (int i = 0; i < NUM_EP; i++) begin
         for (int j = 0; j < NUM_EP; j++) begin
            if (i != j && alloc_i[i] && alloc_i[j] &&
                END_W'(base_i[i]) < end_a[j] && END_W'(base_i[j]) < end_a[i])
               conflict_o[i] = 1'b1;
         end
      end
   end

   // R9
   pair_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(conflict_o) != 1);
   // R9
   idle_no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((conflict_o & ~alloc_i) == '0));
   // R10
   overflow_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((overflow_o & ~alloc_i) == '0));
endmodule

// File: rtl/epbuf_window_alloc.sv
module epbuf_window_alloc
   import epbuf_pkg::*;
#(
   parameter int NUM_EP    = 6,
   parameter int RAM_BYTES = 4096,
   parameter int MIN_SIZE  = 8,
   parameter int SIZE_W    = 3,
   parameter int BANK_W    = 2,
   parameter int MAX_BANKS = 3,
   parameter int ATTR_W    = 8,
   localparam int EP_W     = $clog2(NUM_EP),
   localparam int MAX_LEN  = (MIN_SIZE << ((1 << SIZE_W) - 1)) * MAX_BANKS,
   localparam int LEN_W    = $clog2(MAX_LEN + 1),
   localparam int BASE_W   = $clog2(NUM_EP * MAX_LEN + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [EP_W-1:0]             wr_ep,
   input  logic [1:0]                  wr_op,
   input  logic [ATTR_W-1:0]           wr_data,
   output logic [NUM_EP-1:0]           ep_en,
   output logic [NUM_EP-1:0]           ep_alloc,
   output logic [NUM_EP*SIZE_W-1:0]    ep_size,
   output logic [NUM_EP*BANK_W-1:0]    ep_bank,
   output logic [NUM_EP*ATTR_W-1:0]    ep_attr,
   output logic [NUM_EP*BASE_W-1:0]    win_base,
   output logic [NUM_EP*LEN_W-1:0]     win_len,
   output logic [NUM_EP-1:0]           conflict,
   output logic [NUM_EP-1:0]           overflow
);
   if (NUM_EP < 2) begin : g_bad_num
      $error("epbuf_window_alloc: NUM_EP must be at least 2");
   end
   if (SIZE_W + BANK_W > ATTR_W) begin : g_bad_geom
      $error("epbuf_window_alloc: geometry fields do not fit the data byte");
   end
   if (MAX_BANKS < 1 || MAX_BANKS > (1 << BANK_W)) begin : g_bad_bank
      $error("epbuf_window_alloc: MAX_BANKS out of range for BANK_W");
   end

   wr_op_e op;
   assign op = wr_op_e'(wr_op);

   logic [NUM_EP-1:0][SIZE_W-1:0] size_a;
   logic [NUM_EP-1:0][BANK_W-1:0] bank_a;
   logic [NUM_EP-1:0][ATTR_W-1:0] attr_a;
   logic [NUM_EP-1:0][BASE_W-1:0] base_a;
   logic [NUM_EP-1:0][LEN_W-1:0]  len_a;

   for (genvar i = 0; i < NUM_EP; i++) begin : g_slot
      epbuf_ep_slot #(
         .SIZE_W(SIZE_W), .BANK_W(BANK_W), .ATTR_W(ATTR_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .hit     (wr_en && int'(wr_ep) == i),
         .op      (op),
         .data    (wr_data),
         .en_o    (ep_en[i]),
         .alloc_o (ep_alloc[i]),
         .size_o  (size_a[i]),
         .bank_o  (bank_a[i]),
         .attr_o  (attr_a[i])
      );
   end

   logic              cur_alloc;
   logic [SIZE_W-1:0] cur_size;
   logic [BANK_W-1:0] cur_bank;

   always_comb begin
      cur_alloc = 1'b0;
      cur_size  = '0;
      cur_bank  = '0;
      for (int i = 0; i < NUM_EP; i++) begin
         if (int'(wr_ep) == i) begin
            cur_alloc = ep_alloc[i];
            cur_size  = size_a[i];
            cur_bank  = bank_a[i];
         end
      end
   end

   logic ep_ok, ev_set, ev_clr;
   assign ep_ok  = int'(wr_ep) < NUM_EP;
   assign ev_set = wr_en && ep_ok && op == OP_ALLOC &&  wr_data[0] && !cur_alloc;
   assign ev_clr = wr_en && ep_ok && op == OP_ALLOC && !wr_data[0] &&  cur_alloc;

   logic [LEN_W-1:0] unit_len;
   logic [LEN_W-1:0] new_len;
   assign unit_len = LEN_W'(MIN_SIZE) << cur_size;

   if (MAX_BANKS == 1) begin : g_single_bank
      assign new_len = unit_len;
   end else begin : g_multi_bank
      logic [LEN_W-1:0] bank_cnt;
      always_comb begin
         if (int'(cur_bank) >= MAX_BANKS - 1)
            bank_cnt = LEN_W'(MAX_BANKS);
         else
            bank_cnt = LEN_W'(cur_bank) + LEN_W'(1);
      end
      assign new_len = LEN_W'(unit_len * bank_cnt);
   end

   epbuf_win_track #(
      .NUM_EP(NUM_EP), .EP_W(EP_W), .BASE_W(BASE_W), .LEN_W(LEN_W)
   ) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_set  (ev_set),
      .ev_clr  (ev_clr),
      .ev_ep   (wr_ep),
      .new_len (new_len),
      .alloc_i (ep_alloc),
      .base_q  (base_a),
      .len_q   (len_a)
   );

   epbuf_overlap #(
      .NUM_EP(NUM_EP), .BASE_W(BASE_W), .LEN_W(LEN_W), .RAM_BYTES(RAM_BYTES)
   ) u_overlap (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (ep_alloc),
      .base_i     (base_a),
      .len_i      (len_a),
      .conflict_o (conflict),
      .overflow_o (overflow)
   );

   assign ep_size  = size_a;
   assign ep_bank  = bank_a;
   assign ep_attr  = attr_a;
   assign win_base = base_a;
   assign win_len  = len_a;

   // R11
   idle_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(win_base) && $stable(win_len)));
   // R8
   geom_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == OP_GEOM) |=> ($stable(win_base) && $stable(win_len)));
endmodule

// File: tb/epbuf_window_alloc_test.sv
module epbuf_window_alloc_test;
   localparam int NE = 6;
   localparam int BW = 15;
   localparam int LW = 12;
   localparam int RAM = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_ep = '0;
   logic [1:0] wr_op = '0;
   logic [7:0] wr_data = '0;
   logic [NE-1:0] ep_en, ep_alloc, conflict, overflow;
   logic [NE*3-1:0] ep_size;
   logic [NE*2-1:0] ep_bank;
   logic [NE*8-1:0] ep_attr;
   logic [NE*BW-1:0] win_base;
   logic [NE*LW-1:0] win_len;

   always #5 clk = ~clk;

   epbuf_window_alloc uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ep(wr_ep), .wr_op(wr_op),
      .wr_data(wr_data), .ep_en(ep_en), .ep_alloc(ep_alloc), .ep_size(ep_size),
      .ep_bank(ep_bank), .ep_attr(ep_attr), .win_base(win_base), .win_len(win_len),
      .conflict(conflict), .overflow(overflow)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   int m_en[NE], m_al[NE], m_sz[NE], m_bk[NE], m_at[NE], m_base[NE], m_len[NE];

   function automatic int exp_len(int sz, int bk);
      return (8 * (2 ** sz)) * ((bk >= 2) ? 3 : bk + 1);
   endfunction

   task automatic cmp(string tag, string what, int ep, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s ep%0d %s actual=%0d expected=%0d", tag, ep, what, act, exp);
      end
   endtask

   task automatic do_write(int ep, int op, int d);
      @(negedge clk);
      wr_en = 1'b1; wr_ep = 3'(ep); wr_op = 2'(op); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
      if (ep < NE) begin
         case (op)
            0: m_en[ep] = d & 1;
            2: begin m_sz[ep] = d & 7; m_bk[ep] = (d >> 3) & 3; end
            3: m_at[ep] = d & 255;
            default: begin
               if ((d & 1) == 1 && m_al[ep] == 0) begin
                  int lo = 0;
                  for (int m = 0; m < ep; m++)
                     if (m_al[m] == 1) lo = m_base[m] + m_len[m];
                  m_base[ep] = lo;
                  m_len[ep] = exp_len(m_sz[ep], m_bk[ep]);
                  if (ep + 1 < NE && m_al[ep+1] == 1) m_base[ep+1] = lo + m_len[ep];
                  m_al[ep] = 1;
               end else if ((d & 1) == 0 && m_al[ep] == 1) begin
                  if (ep + 1 < NE && m_al[ep+1] == 1) m_base[ep+1] = m_base[ep];
                  m_base[ep] = 0; m_len[ep] = 0; m_al[ep] = 0;
               end
            end
         endcase
      end
   endtask

   task automatic check_all(string tag);
      for (int i = 0; i < NE; i++) begin
         int cf = 0;
         for (int j = 0; j < NE; j++)
            if (j != i && m_al[i] == 1 && m_al[j] == 1 &&
                m_base[i] < m_base[j] + m_len[j] && m_base[j] < m_base[i] + m_len[i])
               cf = 1;
         cmp("R7", "enable", i, int'(ep_en[i]), m_en[i]);
         cmp("R7", "alloc", i, int'(ep_alloc[i]), m_al[i]);
         cmp("R7", "size", i, int'(ep_size[i*3 +: 3]), m_sz[i]);
         cmp("R7", "bank", i, int'(ep_bank[i*2 +: 2]), m_bk[i]);
         cmp("R7", "attr", i, int'(ep_attr[i*8 +: 8]), m_at[i]);
         cmp(tag, "base", i, int'(win_base[i*BW +: BW]), m_base[i]);
         cmp(tag, "len", i, int'(win_len[i*LW +: LW]), m_len[i]);
         cmp("R9", "conflict", i, int'(conflict[i]), cf);
         cmp("R10", "overflow", i, int'(overflow[i]),
             (m_al[i] == 1 && m_base[i] + m_len[i] > RAM) ? 1 : 0);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog all-requirements actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NE; i++) begin
         m_en[i] = 0; m_al[i] = 0; m_sz[i] = 0; m_bk[i] = 0;
         m_at[i] = 0; m_base[i] = 0; m_len[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R2: sweep every size and bank code on endpoint 0
      for (int sz = 0; sz < 8; sz++) begin
         for (int bk = 0; bk < 4; bk++) begin
            do_write(0, 2, (bk << 3) | sz);
            do_write(0, 1, 1);
            check_all("R2");
            cmp("R2", "len formula", 0, int'(win_len[0 +: LW]), exp_len(sz, bk));
            do_write(0, 1, 0);
            check_all("R5");
         end
      end

      // R3: ascending bring-up, 64 bytes each, with attributes and enables
      for (int e = 0; e < NE; e++) begin
         do_write(e, 2, (0 << 3) | 3);
         do_write(e, 3, 8'h10 + e);
         do_write(e, 0, 1);
         do_write(e, 1, 1);
         check_all("R3");
         cmp("R3", "base ascending", e, int'(win_base[e*BW +: BW]), 64 * e);
      end

      // R11: redundant allocate, redundant free, out-of-range index
      do_write(2, 1, 1);
      check_all("R11");
      do_write(6, 1, 0);
      do_write(7, 0, 0);
      check_all("R11");

      // R7: disable endpoint 3, allocation and configuration stay
      do_write(3, 0, 0);
      check_all("R7");

      // R5: free endpoint 3, endpoint 4 drops to 192, endpoint 5 stays at 320
      do_write(3, 1, 0);
      check_all("R5");
      cmp("R5", "ep4 slid down", 4, int'(win_base[4*BW +: BW]), 192);
      cmp("R6", "ep5 fixed", 5, int'(win_base[5*BW +: BW]), 320);

      // R4: re-allocate endpoint 3 at 128 bytes, endpoint 4 moves onto endpoint 5
      do_write(3, 2, (0 << 3) | 4);
      do_write(3, 1, 1);
      check_all("R4");
      cmp("R4", "ep4 slid up", 4, int'(win_base[4*BW +: BW]), 320);
      cmp("R6", "ep5 fixed", 5, int'(win_base[5*BW +: BW]), 320);
      cmp("R9", "overlap pair", 0, int'(conflict), 6'b110000);

      // R8: geometry change while allocated moves nothing
      do_write(1, 2, (2 << 3) | 7);
      check_all("R8");
      cmp("R8", "len kept", 1, int'(win_len[1*LW +: LW]), 64);

      // R6: free endpoint 1, endpoint 2 slides, endpoints 0,3,4,5 stay
      do_write(1, 1, 0);
      check_all("R6");

      // R10: release everything, then build overflow cases
      for (int e = NE - 1; e >= 0; e--) do_write(e, 1, 0);
      check_all("R5");
      do_write(0, 2, (2 << 3) | 7);
      do_write(0, 1, 1);
      do_write(1, 2, (0 << 3) | 7);
      do_write(1, 1, 1);
      check_all("R10");
      cmp("R10", "end at top", 1, int'(overflow[1]), 0);
      do_write(1, 1, 0);
      do_write(1, 2, (1 << 3) | 7);
      do_write(1, 1, 1);
      check_all("R10");
      cmp("R10", "past top", 1, int'(overflow[1]), 1);

      done = 1;
      summary();
      $finish;
   end
endmodule